// File: doc/BRIEF.md
# Three-Channel Compare General Timer

A memory-mapped up-counting timer. A word-addressed register port reaches ten 32-bit registers. The counter takes its ticks from one of several tick-enable inputs that share the system clock, and it divides them by a 12-bit prescaler. It either runs free through its full range or restarts after matching compare channel 1, which then acts as the period register.

Three compare channels and a rollover detector set sticky status flags. Software clears a flag by writing a one to it. A single level interrupt is raised when an enabled flag is pending and the timer is enabled. A self-clearing software-reset bit returns the block to its reset values, but a chosen set of control fields survives it. The capture registers exist in the map and always read zero.

The counter width is a parameter (`CNT_W`, default 32). The compare registers have the same width, and the count and compare values read back zero-extended. In the text below, MAX is the all-ones count value.

Top module: `gtmr_top`

## Requirements
- R1: Word offsets are 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4/5/6 compare 1/2/3, 7/8 capture 1/2 (always zero) and 9 live count. Offsets 10 to 15 read zero, and writes to them change nothing.
- R2: Control fields are: bit 0 enable (EN), bit 1 restart-on-enable (ENMOD), bit 3 debug enable, bit 5 wait enable, bit 6 doze enable, bit 7 stop enable, bit 9 free-run, bit 15 software reset, and bits [18:16] source select. Bits 2, 4 and 10 to 15 are not stored and read back as zero.
- R3: While enabled, the counter advances once every (prescaler + 1) ticks of the selected source. Writing the prescaler, or an enable that restarts the count, restarts the divide phase.
- R4: Source select codes: 001 picks `tick_per`, 010 picks `tick_per_hi`, 011 picks `tick_ext`, 100 picks `tick_slow`, 101 picks `tick_ref` divided by 8, and 111 picks `tick_ref`. Codes 000 and 110 select nothing, and the count holds.
- R5: In restart mode (free-run bit clear), an advance taken while the count equals compare 1 takes the count to 0.
- R6: In free-run mode the count goes up to MAX and wraps to 0. The advance that leaves MAX sets the rollover flag, status bit 5.
- R7: An advance that makes the count equal compare n sets status bit n-1 (bits 0, 1, 2).
- R8: Writing compare 1 in restart mode sets the count to 0. Writing compare 2 or compare 3 leaves the count alone.
- R9: Writing a one to a status bit in [5:0] clears it. If a flag event and a clear hit the same bit in the same cycle, the bit ends up set.
- R10: `irq` is high exactly when EN is set and (status AND interrupt enable) is nonzero. The interrupt enable register has 6 bits laid out like the status register.
- R11: A write that takes EN from 0 to 1 with ENMOD set restarts the count at 0. With ENMOD clear, counting resumes from the held value. Clearing EN stops the count.
- R12: Reset sets control, prescaler, status, interrupt enable and count to zero, and sets the three compare registers to MAX.
- R13: A control write with bit 15 set applies the reset values of R12, except that EN, ENMOD, the debug/wait/doze/stop enables and the source select keep their previous contents. Bit 15 itself is not kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register word offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| tick_per | input | 1 | Peripheral clock tick enable |
| tick_per_hi | input | 1 | High-frequency peripheral tick enable |
| tick_ext | input | 1 | External tick enable |
| tick_slow | input | 1 | Low-frequency tick enable |
| tick_ref | input | 1 | Reference tick enable |
| irq | output | 1 | Level interrupt |

## Verification
The bench aims a status clear at the exact cycle in which compare 1 matches. A design that let the clear win would lose that event. It writes compare 1 and compare 2 while the count is running, so a block that cleared the count on the wrong channel shows a wrong count. It uses a narrow counter so that rollover can be reached, checking the flag one cycle before and one cycle after the wrap to catch an off-by-one. It also issues a software reset with a word holding only the reset bit; a block that took the preserved fields from that word instead of keeping the old contents would stop counting.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 4;
    localparam int NCMP   = 3;
    localparam int FLAG_W = 6;
    localparam int SRC_W  = 3;

    // control bit positions
    localparam int CB_EN    = 0;
    localparam int CB_ENMOD = 1;
    localparam int CB_DBG   = 3;
    localparam int CB_WAIT  = 5;
    localparam int CB_DOZE  = 6;
    localparam int CB_STOP  = 7;
    localparam int CB_FRR   = 9;
    localparam int CB_SWR   = 15;
    localparam int CB_SRC   = 16;

    // bits that hold state (2, 4, 10..15 are dropped)
    localparam logic [REG_W-1:0] CTRL_STORE = ~32'h0000_FC14;
    // fields that survive a software reset
    localparam logic [REG_W-1:0] SOFT_KEEP =
        (REG_W'(1) << CB_EN)   | (REG_W'(1) << CB_ENMOD) |
        (REG_W'(1) << CB_DBG)  | (REG_W'(1) << CB_WAIT)  |
        (REG_W'(1) << CB_DOZE) | (REG_W'(1) << CB_STOP)  |
        (REG_W'((1 << SRC_W) - 1) << CB_SRC);

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL  = 4'd0,
        RA_PRE   = 4'd1,
        RA_STAT  = 4'd2,
        RA_IEN   = 4'd3,
        RA_CMP1  = 4'd4,
        RA_CMP2  = 4'd5,
        RA_CMP3  = 4'd6,
        RA_CAP1  = 4'd7,
        RA_CAP2  = 4'd8,
        RA_COUNT = 4'd9
    } reg_addr_e;

    typedef enum logic [SRC_W-1:0] {
        SRC_OFF0   = 3'b000,
        SRC_PER    = 3'b001,
        SRC_PERHI  = 3'b010,
        SRC_EXT    = 3'b011,
        SRC_SLOW   = 3'b100,
        SRC_REFDIV = 3'b101,
        SRC_OFF6   = 3'b110,
        SRC_REF    = 3'b111
    } src_e;

    typedef struct packed {
        logic            rov;
        logic            cap2;
        logic            cap1;
        logic [NCMP-1:0] ocf;
    } flag_t;

    function automatic src_e ctrl_src(input logic [REG_W-1:0] c);
        return src_e'(c[CB_SRC +: SRC_W]);
    endfunction

    function automatic flag_t make_flags(input logic [NCMP-1:0] hits, input logic wrap);
        flag_t f;
        f.rov  = wrap;
        f.cap2 = 1'b0;
        f.cap1 = 1'b0;
        f.ocf  = hits;
        return f;
    endfunction
endpackage

// File: rtl/gtmr_tick_sel.sv
module gtmr_tick_sel
    import gtmr_pkg::*;
#(
    parameter int PRE_W = 12,
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             run,
    input  src_e             src,
    input  logic [PRE_W-1:0] pre,
    input  logic             tick_per,
    input  logic             tick_per_hi,
    input  logic             tick_ext,
    input  logic             tick_slow,
    input  logic             tick_ref,
    output logic             step
);
    logic [DIV_W-1:0] div_q;
    logic [PRE_W-1:0] pc_q;
    logic             sel_tick;
    logic             ref_slow;

    assign ref_slow = tick_ref && (div_q == '1);

    always_comb begin
        case (src)
            SRC_PER:    sel_tick = tick_per;
            SRC_PERHI:  sel_tick = tick_per_hi;
            SRC_EXT:    sel_tick = tick_ext;
            SRC_SLOW:   sel_tick = tick_slow;
            SRC_REFDIV: sel_tick = ref_slow;
            SRC_REF:    sel_tick = tick_ref;
            default:    sel_tick = 1'b0;
        endcase
    end

    assign step = run && sel_tick && (pc_q == pre);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            div_q <= '0;
            pc_q  <= '0;
        end else begin
            if (run && (src == SRC_REFDIV) && tick_ref)
                div_q <= div_q + 1'b1;
            if (run && sel_tick)
                pc_q <= (pc_q == pre) ? '0 : pc_q + 1'b1;
        end
    end

    // R4: a "none" code never produces an advance
    a_r4_none_freezes: assert property (@(posedge clk) disable iff (rst)
        ((src == SRC_OFF0) || (src == SRC_OFF6)) |-> !step);
    // R3: each advance starts a fresh divide phase
    a_r3_phase_restart: assert property (@(posedge clk) disable iff (rst)
        step |=> (pc_q == '0));
    // R3: the divide phase holds while the timer is stopped
    a_r3_phase_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !clear) |=> $stable(pc_q));
endmodule

// File: rtl/gtmr_count.sv
module gtmr_count
    import gtmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       zero,
    input  logic                       step,
    input  logic                       free_run,
    input  logic [NCMP-1:0][CNT_W-1:0] cmp,
    output logic [CNT_W-1:0]           cnt,
    output logic [NCMP-1:0]            hit,
    output logic                       wrap
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic             adv;

    assign adv = step && !zero;

    always_comb begin
        if (!free_run && (cnt_q == cmp[0])) cnt_nx = '0;
        else                                 cnt_nx = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || zero)  cnt_q <= '0;
        else if (step)    cnt_q <= cnt_nx;
    end

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        assign hit[g] = adv && (cnt_nx == cmp[g]);
    end

    assign wrap = adv && (cnt_q == '1);
    assign cnt  = cnt_q;

    // R5: restart mode returns to zero after the period match
    a_r5_period_wrap: assert property (@(posedge clk) disable iff (rst)
        (adv && !free_run && (cnt_q == cmp[0])) |=> (cnt_q == '0));
    // R6: free-run mode increments by one, modulo the width
    a_r6_free_inc: assert property (@(posedge clk) disable iff (rst)
        (adv && free_run) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
    // R6: leaving MAX always lands on zero
    a_r6_rollover_zero: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt_q == '0));
    // R11: no advance, no clear -> the count holds
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!step && !zero) |=> $stable(cnt_q));
endmodule

// File: rtl/gtmr_top.sv
module gtmr_top
    import gtmr_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PRE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              tick_per,
    input  logic              tick_per_hi,
    input  logic              tick_ext,
    input  logic              tick_slow,
    input  logic              tick_ref,
    output logic              irq
);
    logic [REG_W-1:0]           ctrl_q;
    logic [PRE_W-1:0]           pre_q;
    logic [FLAG_W-1:0]          stat_q;
    logic [FLAG_W-1:0]          ien_q;
    logic [NCMP-1:0][CNT_W-1:0] cmp_q;
    logic [NCMP-1:0]            wr_cmp;
    logic [CNT_W-1:0]           cnt;
    logic [NCMP-1:0]            hit;
    logic                       wrap;
    logic                       step;
    flag_t                      set_flags;
    logic [FLAG_W-1:0]          set_vec;
    logic [FLAG_W-1:0]          stat_clr;
    logic wr_ctrl, wr_pre, wr_stat, wr_ien;
    logic soft_rst, en_rise, cnt_zero, phase_clr;
    logic en, free_run;

    assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
    assign wr_pre  = reg_we && (reg_addr == RA_PRE);
    assign wr_stat = reg_we && (reg_addr == RA_STAT);
    assign wr_ien  = reg_we && (reg_addr == RA_IEN);

    always_comb begin
        for (int i = 0; i < NCMP; i++)
            wr_cmp[i] = reg_we && (reg_addr == ADDR_W'(32'(RA_CMP1) + i));
    end

    assign en       = ctrl_q[CB_EN];
    assign free_run = ctrl_q[CB_FRR];
    assign soft_rst = wr_ctrl && reg_wdata[CB_SWR];
    assign en_rise  = wr_ctrl && !soft_rst && !en &&
                      reg_wdata[CB_EN] && reg_wdata[CB_ENMOD];
    assign cnt_zero  = soft_rst || en_rise || (wr_cmp[0] && !free_run);
    assign phase_clr = soft_rst || en_rise || wr_pre;

    gtmr_tick_sel #(.PRE_W(PRE_W), .DIV_W(3)) u_tick (
        .clk         (clk),
        .rst         (rst),
        .clear       (phase_clr),
        .run         (en),
        .src         (ctrl_src(ctrl_q)),
        .pre         (pre_q),
        .tick_per    (tick_per),
        .tick_per_hi (tick_per_hi),
        .tick_ext    (tick_ext),
        .tick_slow   (tick_slow),
        .tick_ref    (tick_ref),
        .step        (step)
    );

    gtmr_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst      (rst),
        .zero     (cnt_zero),
        .step     (step),
        .free_run (free_run),
        .cmp      (cmp_q),
        .cnt      (cnt),
        .hit      (hit),
        .wrap     (wrap)
    );

    assign set_flags = make_flags(hit, wrap);
    assign set_vec   = set_flags;
    assign stat_clr  = wr_stat ? reg_wdata[FLAG_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            pre_q  <= '0;
            stat_q <= '0;
            ien_q  <= '0;
        end else if (soft_rst) begin
            ctrl_q <= ctrl_q & SOFT_KEEP;
            pre_q  <= '0;
            stat_q <= '0;
            ien_q  <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= reg_wdata & CTRL_STORE;
            if (wr_pre)  pre_q  <= reg_wdata[PRE_W-1:0];
            if (wr_ien)  ien_q  <= reg_wdata[FLAG_W-1:0];
            stat_q <= (stat_q & ~stat_clr) | set_vec;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NCMP; i++) begin
            if (rst || soft_rst)  cmp_q[i] <= '1;
            else if (wr_cmp[i])   cmp_q[i] <= reg_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        case (reg_addr_e'(reg_addr))
            RA_CTRL:  reg_rdata = ctrl_q;
            RA_PRE:   reg_rdata = REG_W'(pre_q);
            RA_STAT:  reg_rdata = REG_W'(stat_q);
            RA_IEN:   reg_rdata = REG_W'(ien_q);
            RA_CMP1:  reg_rdata = REG_W'(cmp_q[0]);
            RA_CMP2:  reg_rdata = REG_W'(cmp_q[1]);
            RA_CMP3:  reg_rdata = REG_W'(cmp_q[2]);
            RA_COUNT: reg_rdata = REG_W'(cnt);
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = en && |(stat_q & ien_q);

    // R9: a flag event always lands, even against a clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|set_vec && !soft_rst) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));
    // R9: written ones clear the bits that saw no event
    a_r9_w1c: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && !soft_rst) |=> ((stat_q & $past(reg_wdata[FLAG_W-1:0] & ~set_vec)) == '0));
    // R13: software reset keeps only the selected control fields
    a_r13_soft_keep: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> ((ctrl_q == ($past(ctrl_q) & SOFT_KEEP)) && (cnt == '0) && (stat_q == '0)));
    // R8: a compare 1 write in restart mode zeroes the count
    a_r8_cmp1_zero: assert property (@(posedge clk) disable iff (rst)
        (wr_cmp[0] && !free_run) |=> (cnt == '0));
    // R11: an enable with ENMOD restarts at zero
    a_r11_enmod_restart: assert property (@(posedge clk) disable iff (rst)
        en_rise |=> (cnt == '0));
endmodule

// File: tb/gtmr_top_tb.sv
`timescale 1ns/1ps
module gtmr_top_tb;
    localparam int CLK_P = 8;
    localparam int TB_CNT_W = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int issued = 0;
    int served = 0;
    bit finished = 0;

    typedef struct {
        string       tag;
        bit          is_irq;
        logic [31:0] exp;
    } item_t;
    item_t exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    gtmr_top #(.CNT_W(TB_CNT_W), .PRE_W(12)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .reg_addr    (reg_addr),
        .reg_we      (reg_we),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .tick_per    (1'b1),
        .tick_per_hi (1'b0),
        .tick_ext    (1'b0),
        .tick_slow   (1'b0),
        .tick_ref    (1'b1),
        .irq         (irq)
    );

    // monitor: pops one expected item per cycle, just after the falling edge
    initial begin
        item_t it;
        logic [31:0] got;
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                it = exp_q.pop_front();
                got = it.is_irq ? {31'b0, irq} : reg_rdata;
                checks++;
                if (got !== it.exp) begin
                    fails++;
                    $display("FAIL %s actual=0x%08h expected=0x%08h", it.tag, got, it.exp);
                end
                served++;
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic exp_rd(input logic [3:0] a, input logic [31:0] e, input string tag);
        item_t it;
        reg_addr = a;
        it.tag = tag; it.is_irq = 1'b0; it.exp = e;
        exp_q.push_back(it);
        issued++;
        wait (served == issued);
    endtask

    task automatic exp_irq(input logic e, input string tag);
        item_t it;
        it.tag = tag; it.is_irq = 1'b1; it.exp = {31'b0, e};
        exp_q.push_back(it);
        issued++;
        wait (served == issued);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 reset values
        exp_rd(4'd0, 32'h0, "R12 control");
        exp_rd(4'd1, 32'h0, "R12 prescaler");
        exp_rd(4'd2, 32'h0, "R12 status");
        exp_rd(4'd3, 32'h0, "R12 enable");
        exp_rd(4'd4, 32'hFF, "R12 compare1");
        exp_rd(4'd5, 32'hFF, "R12 compare2");
        exp_rd(4'd6, 32'hFF, "R12 compare3");
        exp_rd(4'd9, 32'h0, "R12 count");
        exp_rd(4'd7, 32'h0, "R1 capture1");
        exp_rd(4'd8, 32'h0, "R1 capture2");
        exp_irq(1'b0, "R12 irq");

        // R2 unstored control bits
        wr(4'd0, 32'h0000_7C14 | 32'h200);
        exp_rd(4'd0, 32'h200, "R2 unstored bits");
        wr(4'd0, 32'h0);
        // R1 unmapped offset
        wr(4'd12, 32'hFFFF_FFFF);
        exp_rd(4'd12, 32'h0, "R1 unmapped read");
        exp_rd(4'd0, 32'h0, "R1 unmapped write ignored");
        exp_rd(4'd9, 32'h0, "R1 count untouched");

        // restart mode, period 6
        wr(4'd3, 32'h1);
        wr(4'd4, 32'd5);
        wr(4'd0, 32'h0001_0003);
        exp_rd(4'd9, 32'd0, "R11 enmod start");
        exp_rd(4'd9, 32'd1, "R3 count step");
        idle(2);
        wr(4'd2, 32'h1);                 // clear lands on the match cycle
        exp_rd(4'd2, 32'h1, "R9 set wins");
        exp_irq(1'b1, "R10 irq high");
        exp_rd(4'd9, 32'd1, "R5 period wrap");
        wr(4'd2, 32'h1);
        exp_rd(4'd2, 32'h0, "R9 w1c");
        exp_irq(1'b0, "R10 irq low");
        idle(1);
        exp_rd(4'd2, 32'h1, "R7 compare1 flag");
        exp_rd(4'd9, 32'd0, "R5 back to zero");
        wr(4'd5, 32'd40);
        exp_rd(4'd9, 32'd2, "R8 compare2 no disturb");
        wr(4'd4, 32'd50);
        exp_rd(4'd9, 32'd0, "R8 compare1 zeroes");
        wr(4'd0, 32'h0001_0000);
        exp_rd(4'd9, 32'd2, "R11 stop value");
        idle(4);
        exp_rd(4'd9, 32'd2, "R11 stopped");
        exp_irq(1'b0, "R10 gated by enable");
        exp_rd(4'd2, 32'h1, "R10 status kept");
        wr(4'd0, 32'h0001_0001);
        exp_rd(4'd9, 32'd2, "R11 resume held");
        exp_rd(4'd9, 32'd3, "R11 resume counts");
        exp_irq(1'b1, "R10 irq re-enabled");
        wr(4'd0, 32'h0001_0000);
        wr(4'd0, 32'h0001_0003);
        exp_rd(4'd9, 32'd0, "R11 enmod restart");

        // R3 prescaler 2 -> every third tick
        wr(4'd0, 32'h0001_0000);
        wr(4'd1, 32'd2);
        wr(4'd0, 32'h0001_0003);
        idle(9);
        exp_rd(4'd9, 32'd3, "R3 divide by 3");
        exp_rd(4'd9, 32'd3, "R3 between steps");
        exp_rd(4'd1, 32'd2, "R3 prescaler read");

        // R4 source select
        wr(4'd0, 32'h0001_0000);
        wr(4'd1, 32'd0);
        wr(4'd0, 32'h0005_0203);
        idle(16);
        exp_rd(4'd9, 32'd2, "R4 ref div 8");
        wr(4'd0, 32'h0006_0201);
        exp_rd(4'd9, 32'd2, "R4 none code");
        idle(5);
        exp_rd(4'd9, 32'd2, "R4 none frozen");
        wr(4'd0, 32'h0007_0201);
        idle(3);
        exp_rd(4'd9, 32'd5, "R4 ref direct");

        // free-run, flags and rollover
        wr(4'd0, 32'h0001_0200);
        wr(4'd2, 32'h3F);
        wr(4'd3, 32'h22);
        wr(4'd0, 32'h0001_0203);
        exp_rd(4'd9, 32'd0, "R6 start");
        idle(39);
        exp_rd(4'd2, 32'h0, "R7 before compare2");
        exp_rd(4'd2, 32'h2, "R7 compare2 flag");
        exp_irq(1'b1, "R10 compare2 irq");
        wr(4'd2, 32'h2);
        exp_irq(1'b0, "R9 cleared irq");
        idle(211);
        exp_rd(4'd9, 32'd254, "R6 near max");
        exp_rd(4'd2, 32'h05, "R6 at max no rollover");
        exp_rd(4'd2, 32'h25, "R6 rollover flag");
        exp_rd(4'd9, 32'd1, "R6 wrapped count");
        exp_irq(1'b1, "R10 rollover irq");

        // R13 software reset with only the reset bit in the word
        wr(4'd1, 32'd3);
        wr(4'd0, 32'h0001_020B);
        wr(4'd0, 32'h0000_8000);
        exp_rd(4'd9, 32'd0, "R13 count cleared");
        exp_rd(4'd9, 32'd1, "R13 still enabled");
        exp_rd(4'd0, 32'h0001_000B, "R13 kept fields");
        exp_rd(4'd1, 32'h0, "R13 prescaler");
        exp_rd(4'd2, 32'h0, "R13 status");
        exp_rd(4'd3, 32'h0, "R13 enable reg");
        exp_rd(4'd5, 32'hFF, "R13 compare2");
        exp_irq(1'b0, "R13 irq");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule